// File: doc/BRIEF.md
# Time-Division-Multiplexed Frame Serializer

This block merges 32 byte-wide channels into one serial bit stream. Time is divided into repeating frames of 256 bit periods. A free-running bit counter, advanced by the bit-rate clock, tracks the position inside the frame. Its low three bits give the bit position within an 8-bit timeslot, and its high five bits give the timeslot number. At a 2.048 MHz bit clock a frame lasts 125 us, so each channel is sent 8000 times per second.

A single shift register drives the serial output. It reloads once per timeslot, on the last bit of that slot, with the byte of the channel that owns the following slot. Between reloads it shifts left, so each byte leaves most-significant bit first. A frame marker output is high during the last bit period of every frame. The current timeslot number is exported so that downstream logic can tag or check the stream.

The bit clock is the block clock. The channel bytes arrive as one flat vector. Channel n occupies bits [8n+7:8n], and the block samples each byte only at its load edge.

Top module: `tdm_frame_serializer`

## Requirements
- R1: The frame position counter runs 0,1,...,255 and wraps to 0, advancing one step per clock. `slot_num` equals the counter's upper five bits, so it stays at each value for 8 clocks.
- R2: `frame_sync` is 1 exactly while the counter equals 255 (timeslot 31, bit 7) and 0 in the other 255 positions of the frame.
- R3: While the counter equals 8n+b, `ser_data` carries bit (7-b) of the byte assigned to timeslot n. Bits are sent most-significant first, one per clock. The byte for timeslot n is taken from `chan_bytes[8n+7:8n]`.
- R4: The byte for timeslot (n+1) mod 32 is sampled on the clock edge that ends bit 7 of timeslot n. A change on `chan_bytes` at any other time has no effect on the bits already being sent.
- R5: At the frame wrap, the edge that ends counter value 255 loads channel 0's byte, so timeslot 0 of the following frame carries channel 0.
- R6: A synchronous active-low reset clears the counter to 0 and the shift register to zero. While reset is held, `slot_num`=0, `frame_sync`=0 and `ser_data`=0. In the first timeslot 0 after reset, `ser_data` is 0 for all 8 bits.
- R7: A reset applied in the middle of a frame restarts the stream at counter value 0. The next load is then at counter value 7, which loads channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_bytes | input | 256 | Channel bytes, channel n at bits [8n+7:8n] |
| ser_data | output | 1 | Serial output, MSB first |
| frame_sync | output | 1 | High during the last bit period of each frame |
| slot_num | output | 5 | Current timeslot number |

## Verification
The hardest case to bring about is a change on a channel byte in the same period as that channel's load edge, or just after it. The bench must show that the sampled value is the one present at the edge and that later changes do not affect it. To reach this case, random stimulus rewrites randomly chosen channels at random bit positions across several frames. Directed phases add the wrap from slot 31 to slot 0 with contrasting bytes, and a reset in the middle of a frame.

// File: rtl/tdm_pkg.sv
// Package: default geometry of the TDM frame serializer.
// Assumes both counts are powers of two, so the counter wraps naturally.
package tdm_pkg;
    localparam int DEF_SLOT_BITS = 8;
    localparam int DEF_NUM_SLOTS = 32;
endpackage

// File: rtl/tdm_bit_counter.sv
// Module: frame position counter.
// It counts 0 up to 2**CNT_W-1, wraps to 0, and flags the terminal count.
// Assumes: rst_n is synchronous and active low.
module tdm_bit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             at_top
);
    // Purpose: advance the frame position once per bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Purpose: decode the terminal count (last bit of the frame).
    always_comb at_top = (cnt == {CNT_W{1'b1}});

    // R1: the counter wraps from terminal count to zero
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        at_top |=> (cnt == '0));
    // R1: otherwise the counter steps by one
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !at_top |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/tdm_slot_select.sv
// Module: selects the byte of the timeslot after the current one.
// Assumes: NUM_SLOTS is a power of two, so the successor of the last
// slot is slot 0.
module tdm_slot_select #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS*SLOT_BITS-1:0] chan_bytes,
    input  logic [SLOT_W-1:0]              cur_slot,
    output logic [SLOT_BITS-1:0]           next_byte
);
    logic [SLOT_BITS-1:0] lane [NUM_SLOTS];
    logic [SLOT_W-1:0]    next_slot;

    // Purpose: split the flat vector into one lane per channel.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        assign lane[g] = chan_bytes[g*SLOT_BITS +: SLOT_BITS];
    end

    // Purpose: pick the successor timeslot's byte.
    always_comb begin
        next_slot = cur_slot + 1'b1;
        next_byte = lane[next_slot];
    end
endmodule

// File: rtl/tdm_shift_out.sv
// Module: parallel-load, MSB-first output shift register.
// Assumes: load has priority over shifting; zeros fill in from the bottom.
module tdm_shift_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         ser_out
);
    logic [W-1:0] shreg;

    // Purpose: load a new byte or shift the current one left.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (load) shreg <= load_val;
        else           shreg <= {shreg[W-2:0], 1'b0};
    end

    // Purpose: the MSB drives the line.
    always_comb ser_out = shreg[W-1];

    // R3: without a load, the register shifts toward the MSB
    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (shreg == {$past(shreg[W-2:0]), 1'b0}));
    // R4: a load captures the value present at the edge
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shreg == $past(load_val)));
endmodule

// File: rtl/tdm_frame_serializer.sv
// Module: TDM frame serializer (top).
// It sends NUM_SLOTS channels of SLOT_BITS bits each, frame after frame.
// The shift register reloads on the last bit of each slot with the byte of
// the following slot.
// Assumes: clk is the bit clock, and rst_n is synchronous and active low.
module tdm_frame_serializer
    import tdm_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS),
    localparam int CNT_W    = SLOT_W + BIT_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SLOTS*SLOT_BITS-1:0] chan_bytes,
    output logic                           ser_data,
    output logic                           frame_sync,
    output logic [SLOT_W-1:0]              slot_num
);
    logic [CNT_W-1:0]     pos;
    logic                 pos_top;
    logic                 load_now;
    logic [SLOT_BITS-1:0] next_byte;

    tdm_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(pos), .at_top(pos_top)
    );

    tdm_slot_select #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_sel (
        .chan_bytes(chan_bytes), .cur_slot(pos[CNT_W-1:BIT_W]),
        .next_byte(next_byte)
    );

    // Purpose: decode slot number, load strobe and frame marker.
    always_comb begin
        slot_num   = pos[CNT_W-1:BIT_W];
        load_now   = (pos[BIT_W-1:0] == {BIT_W{1'b1}});
        frame_sync = pos_top;
    end

    tdm_shift_out #(.W(SLOT_BITS)) u_shf (
        .clk(clk), .rst_n(rst_n), .load(load_now),
        .load_val(next_byte), .ser_out(ser_data)
    );

    // R2: the frame marker is followed by slot 0
    assert_sync_then_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (slot_num == '0) && !frame_sync);
    // R5: the wrap load puts channel 0's MSB on the line
    assert_wrap_loads_ch0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (ser_data == $past(chan_bytes[SLOT_BITS-1])));
    // R6: the first bit after reset is low and the stream starts at slot 0
    assert_reset_state_R6: assert property (@(posedge clk)
        !rst_n |=> (slot_num == '0) && !ser_data && !frame_sync);
endmodule

// File: tb/tdm_frame_serializer_test.sv
module tdm_frame_serializer_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] chan_bytes = '0;
    logic         ser_data;
    logic         frame_sync;
    logic [4:0]   slot_num;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int       k;          // model frame position
    logic [7:0] cur_b;    // byte expected in the current slot
    logic [7:0] nxt_b;    // byte captured for the next slot

    always #5 clk = ~clk;

    tdm_frame_serializer uut (
        .clk(clk), .rst_n(rst_n), .chan_bytes(chan_bytes),
        .ser_data(ser_data), .frame_sync(frame_sync), .slot_num(slot_num)
    );

    function automatic logic [7:0] chan_of(logic [255:0] v, int n);
        return v[n*8 +: 8];
    endfunction

    function automatic logic exp_bit(logic [7:0] b, int pos);
        return b[7 - (pos % 8)];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at pos %0d: actual %0h expected %0h", tag, k, act, exp);
        end
    endtask

    // One bit period at a negedge: compare, optionally churn inputs, model a load.
    task automatic step(int churn);
        if (k % 8 == 0) cur_b = nxt_b;
        check("R1 slot_num", 32'(slot_num), 32'(k / 8));
        check("R2 frame_sync", 32'(frame_sync), 32'(k == 255));
        check("R3/R4/R5 ser_data", 32'(ser_data), 32'(exp_bit(cur_b, k)));
        if (churn > 0 && ($urandom % 4) == 0)
            chan_bytes[($urandom % 32)*8 +: 8] = 8'($urandom);
        if (k % 8 == 7) nxt_b = chan_of(chan_bytes, ((k / 8) + 1) % 32);
        k = (k + 1) % 256;
        @(negedge clk);
    endtask

    task automatic do_reset(int cycles);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < cycles; i++) begin
            check("R6 reset slot", 32'(slot_num), 32'd0);
            check("R6 reset sync", 32'(frame_sync), 32'd0);
            check("R6 reset data", 32'(ser_data), 32'd0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        k = 0;
        cur_b = 8'h00;
        nxt_b = 8'h00;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(3);
        // Directed: distinct bytes per channel, no churn (R3, R6 first slot zero).
        for (int n = 0; n < 32; n++) chan_bytes[n*8 +: 8] = 8'hA5 ^ 8'(n * 7);
        for (int i = 0; i < 512; i++) step(0);
        // Directed wrap: slot 31 all ones, slot 0 all zeros, then swapped (R5).
        chan_bytes[31*8 +: 8] = 8'hFF;
        chan_bytes[0 +: 8] = 8'h00;
        for (int i = 0; i < 256; i++) step(0);
        chan_bytes[31*8 +: 8] = 8'h00;
        chan_bytes[0 +: 8] = 8'h81;
        for (int i = 0; i < 256; i++) step(0);
        // Random churn across frames (R4: only the load-edge value counts).
        for (int i = 0; i < 1024; i++) step(1);
        // Reset mid-frame, then restart (R7).
        for (int i = 0; i < 77; i++) step(1);
        do_reset(2);
        for (int i = 0; i < 16; i++) step(0); // R7: slot 0 zero, slot 1 loads channel 1
        for (int i = 0; i < 600; i++) step(1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule